// File: doc/BRIEF.md
# Idle Line Detector

This block watches a host's asynchronous serial data line and a single "carrier present" input, and drives an active-high idle flag. The flag tells the host and the other nodes on a shared medium that the channel is free and that arbitration for the next message may begin. The block frames characters on the serial line using a bit-time counter. It recognises the end of a message as a run of consecutive ones after a stop bit. It then holds the flag low for a fixed number of further bit times, so that every node sees the same quiet interval before contending.

A frame-length input chooses between two character sizes. The chosen size is captured when each start bit is accepted. The bit time is a whole number of clock cycles, and the counter that measures it is realigned to every accepted start edge. Any carrier indication drops the flag at once and restarts the quiet-interval count. An asynchronous active-low reset returns the block to the idle state.

Top module: `idle_line_detector`

## Requirements
- R1: While `rst_n` is low, `idle_o` is high without waiting for a clock edge. After reset is released with the line high and no carrier, `idle_o` stays high.
- R2: A falling edge on `ser_in` that arrives outside a character is a start bit. It passes through two synchronizer stages and an edge register. When `ser_in` falls just before clock edge 1, `idle_o` is still high after edge 2 and low after edge 3.
- R3: `short_frame` = 1 selects a 10-bit character: one low start bit, 8 data bits sent LSB first, and one stop bit. `short_frame` = 0 selects an 11-bit character with 9 data bits. The value is taken when the start bit is accepted.
- R4: Data bits inside a character never count toward end of message, even when they contain long runs of ones, and `idle_o` stays low for the whole character.
- R5: End of message is TRAIL_ONES (5) consecutive high samples, one per bit time, after the stop bit. A new start bit that arrives after a gap of 0 to TRAIL_ONES-1 bit times continues the same message.
- R6: `idle_o` rises HOLD_BITS (10) bit times after the end-of-message sample. Counting the edge after the start bit of the last character falls as edge 1, `idle_o` is low after edge 3+H+(F+TRAIL_ONES-1+HOLD_BITS)·B and high after the next edge. Here B = BIT_CYCLES, H = B/2 and F = frame length.
- R7: A high `carrier_in` drives `idle_o` low after the next clock edge and restarts the quiet count. Counting the first edge with `carrier_in` low as edge 1, `idle_o` is still low after edge 9·B and high after edge 10·B (HOLD_BITS = 10). A carrier pulse inside a character does not move the end-of-message timing.
- R8: Each bit is sampled once per BIT_CYCLES clocks, B/2 cycles into the bit time measured from the accepted start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Host serial data line, high when quiet |
| carrier_in | input | 1 | Carrier-present indication from the receive side |
| short_frame | input | 1 | 1: 10-bit character, 0: 11-bit character |
| idle_o | output | 1 | High when the channel is free for arbitration |

## Verification
The bench builds the block with BIT_CYCLES = 8 and keeps the default trailing-ones and holdoff counts. This shortens a whole message to about two hundred cycles. At that length the bench can send every 8-bit data value and a strided sweep of 9-bit values, and it checks the exact rise cycle of the flag against the closed-form latency each time. The short bit time also allows sweeps of inter-character gaps on both sides of the end-of-message threshold, carrier pulses during a character and during the holdoff, and a reset in the middle of a character.

// File: rtl/idl_pkg.sv
package idl_pkg;

  typedef enum logic [1:0] {
    TRK_WAIT  = 2'd0,
    TRK_FRAME = 2'd1,
    TRK_TRAIL = 2'd2
  } trk_state_t;

  // number of bit slots in one character, start and stop included
  function automatic logic [3:0] frame_bits(input logic short_sel);
    return short_sel ? 4'd10 : 4'd11;
  endfunction

  // cycle offset inside a bit time at which the line is sampled
  function automatic int sample_phase(input int bit_cycles);
    return bit_cycles / 2;
  endfunction

endpackage

// File: rtl/idl_line_sync.sv
module idl_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_i,
  output logic line_o,
  output logic fall_o
);
  logic s1_q, s2_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      prv_q <= 1'b1;
    end else begin
      s1_q  <= ser_i;
      s2_q  <= s1_q;
      prv_q <= s2_q;
    end
  end

  assign line_o = s2_q;
  assign fall_o = prv_q & ~s2_q;

  // R2
  fall_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(line_o));
endmodule

// File: rtl/idl_bit_timer.sv
module idl_bit_timer #(
  parameter int BIT_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  import idl_pkg::*;

  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] PHASE = CW'(sample_phase(BIT_CYCLES));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == PHASE);

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/idl_frame_track.sv
module idl_frame_track #(
  parameter int TRAIL_ONES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic fall_i,
  input  logic tick_i,
  input  logic short_i,
  output logic start_o,
  output logic eop_o,
  output logic busy_o
);
  import idl_pkg::*;

  localparam int OW = $clog2(TRAIL_ONES + 1);
  localparam logic [OW-1:0] ONES_LAST = OW'(TRAIL_ONES - 1);

  trk_state_t    state_q;
  logic [3:0]    bit_idx_q;
  logic [3:0]    flen_q;
  logic [OW-1:0] ones_q;

  assign start_o = fall_i && (state_q != TRK_FRAME);
  assign eop_o   = (state_q == TRK_TRAIL) && !fall_i && tick_i && line_i
                   && (ones_q == ONES_LAST);
  assign busy_o  = (state_q != TRK_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TRK_WAIT;
      bit_idx_q <= '0;
      flen_q    <= 4'd10;
      ones_q    <= '0;
    end else if (start_o) begin
      state_q   <= TRK_FRAME;
      bit_idx_q <= '0;
      flen_q    <= frame_bits(short_i);
      ones_q    <= '0;
    end else begin
      case (state_q)
        TRK_FRAME: if (tick_i) begin
          if (bit_idx_q == flen_q - 4'd1) begin
            state_q <= TRK_TRAIL;
            ones_q  <= '0;
          end else begin
            bit_idx_q <= bit_idx_q + 4'd1;
          end
        end
        TRK_TRAIL: if (tick_i) begin
          if (eop_o)       state_q <= TRK_WAIT;
          else if (line_i) ones_q  <= ones_q + 1'b1;
          else             ones_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  // R3
  bit_idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_FRAME) |-> (bit_idx_q < flen_q));
  // R5
  trail_ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q < OW'(TRAIL_ONES));
  // R5
  eop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !busy_o);
endmodule

// File: rtl/idle_line_detector.sv
module idle_line_detector #(
  parameter int BIT_CYCLES = 1250,
  parameter int HOLD_BITS  = 10,
  parameter int TRAIL_ONES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic carrier_in,
  input  logic short_frame,
  output logic idle_o
);
  localparam int HW = $clog2(HOLD_BITS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_BITS - 1);

  logic line_w, fall_w, tick_w, start_w, eop_w, busy_w;
  logic idle_q;
  logic [HW-1:0] hold_q;

  idl_line_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_i  (ser_in),
    .line_o (line_w),
    .fall_o (fall_w)
  );

  idl_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (start_w),
    .tick_o    (tick_w)
  );

  idl_frame_track #(.TRAIL_ONES(TRAIL_ONES)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_w),
    .fall_i  (fall_w),
    .tick_i  (tick_w),
    .short_i (short_frame),
    .start_o (start_w),
    .eop_o   (eop_w),
    .busy_o  (busy_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      hold_q <= '0;
    end else if (carrier_in || start_w) begin
      idle_q <= 1'b0;
      hold_q <= '0;
    end else if (busy_w) begin
      hold_q <= '0;
    end else if (tick_w && !idle_q) begin
      if (hold_q == HOLD_LAST) begin
        idle_q <= 1'b1;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign idle_o = idle_q;

  // R7
  carrier_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_in |=> !idle_o);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !idle_o);
  // R4
  busy_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !idle_o);
  // R6
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> ($past(tick_w) && !$past(busy_w) && !$past(carrier_in)));
  // R5
  eop_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_w |=> !idle_o);
endmodule

// File: tb/sim_idle_line_detector.sv
module sim_idle_line_detector;
  localparam int B     = 8;
  localparam int HALF  = B / 2;
  localparam int TRAIL = 5;
  localparam int HOLD  = 10;

  logic clk = 1'b0;
  logic rst_n, ser, carrier, short_sel;
  logic idle_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idle_line_detector #(.BIT_CYCLES(B), .HOLD_BITS(HOLD), .TRAIL_ONES(TRAIL)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser),
    .carrier_in  (carrier),
    .short_frame (short_sel),
    .idle_o      (idle_o)
  );

  function automatic int rise_at(input int flen);
    return 4 + HALF + (flen + TRAIL - 1 + HOLD) * B;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: idle_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_chars(input int nch, input logic [8:0] d0, input logic [8:0] d1,
                            input logic [8:0] d2, input bit fs, input int gap);
    int flen;
    logic [8:0] d;
    flen = fs ? 10 : 11;
    short_sel = fs;
    for (int c = 0; c < nch; c++) begin
      d = (c == 0) ? d0 : (c == 1) ? d1 : d2;
      for (int b = 0; b < flen; b++) begin
        ser = (b == 0) ? 1'b0 : (b == flen - 1) ? 1'b1 : d[b-1];
        for (int i = 1; i <= B; i++) begin
          @(negedge clk);
          if (c == 0 && b == 0 && i == 2) check("R2", idle_o, 1'b1);
          if (c == 0 && b == 0 && i == 3) check("R2", idle_o, 1'b0);
        end
      end
      check("R4", idle_o, 1'b0);
      if (c < nch - 1) begin
        repeat (gap * B) @(negedge clk);
        check("R5", idle_o, 1'b0);
      end
    end
  endtask

  task automatic run_msg(input int nch, input logic [8:0] d0, input logic [8:0] d1,
                         input logic [8:0] d2, input bit fs, input int gap, input string req);
    int flen;
    flen = fs ? 10 : 11;
    send_chars(nch, d0, d1, d2, fs, gap);
    repeat (rise_at(flen) - 1 - flen * B) @(negedge clk);
    check(req, idle_o, 1'b0);
    @(negedge clk);
    check(req, idle_o, 1'b1);
  endtask

  task automatic expect_holdoff(input string req);
    repeat (9 * B) @(negedge clk);
    check(req, idle_o, 1'b0);
    repeat (B) @(negedge clk);
    check(req, idle_o, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; ser = 1'b1; carrier = 1'b0; short_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", idle_o, 1'b1);
    rst_n = 1'b1;
    repeat (3 * B) @(negedge clk);
    check("R1", idle_o, 1'b1);

    // R6 / R4 / R8: every 8-bit value, rise cycle fixed by arithmetic
    for (int v = 0; v < 256; v++) run_msg(1, 9'(v), 9'h0, 9'h0, 1'b1, 0, "R6");
    // R3: 11-bit characters, strided 9-bit values
    for (int v = 0; v < 512; v += 11) run_msg(1, 9'(v), 9'h0, 9'h0, 1'b0, 0, "R3");
    // R5: gaps 0..4 keep one message, both frame sizes
    for (int f = 0; f < 2; f++)
      for (int g = 0; g <= 4; g++)
        run_msg(3, 9'h0FF, 9'h1FF, 9'h055, f[0], g, "R5");
    // R5: gap of exactly TRAIL bits ends the message, next character restarts it
    run_msg(2, 9'h0A5, 9'h05A, 9'h0, 1'b1, TRAIL, "R5");
    run_msg(2, 9'h1A5, 9'h05A, 9'h0, 1'b0, TRAIL, "R5");

    // R7: carrier from idle
    carrier = 1'b1;
    @(negedge clk);
    check("R7", idle_o, 1'b0);
    repeat (3 * B) @(negedge clk);
    check("R7", idle_o, 1'b0);
    carrier = 1'b0;
    expect_holdoff("R7");

    // R7: carrier pulse inside a character leaves end-of-message timing alone
    fork
      run_msg(1, 9'h0C3, 9'h0, 9'h0, 1'b1, 0, "R7");
      begin
        repeat (4 * B) @(negedge clk);
        carrier = 1'b1;
        @(negedge clk);
        carrier = 1'b0;
      end
    join

    // R7: carrier pulse during holdoff restarts it
    send_chars(1, 9'h033, 9'h0, 9'h0, 1'b1, 0);
    repeat (6 * B) @(negedge clk);
    carrier = 1'b1;
    @(negedge clk);
    check("R7", idle_o, 1'b0);
    carrier = 1'b0;
    expect_holdoff("R7");

    // R1: asynchronous reset in the middle of a character
    short_sel = 1'b1;
    ser = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", idle_o, 1'b0);
    #2 rst_n = 1'b0;
    #1 check("R1", idle_o, 1'b1);
    ser = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * B) @(negedge clk);
    check("R1", idle_o, 1'b1);
    run_msg(1, 9'h0F0, 9'h0, 9'h0, 1'b1, 0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule